// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Selector

This block picks, on every clock, at most one hardware thread whose next instruction may enter a long execution pipeline that has no bypass network. Each candidate instruction comes with a 3-bit lookahead count, supplied by the compiler, giving how many of the thread's following instructions do not depend on it. The selector keeps a small state machine per thread. A thread may issue back to back while lookahead credit remains. When the credit runs out it waits until its newest instruction has left the pipeline, which is `DEPTH` cycles after it issued. A memory operation removes its thread from selection until a completion pulse for that thread arrives.

Each thread state machine has four states. TS_IDLE means nothing is in flight; the thread is eligible. TS_GROUP means instructions are in flight and credit is left; the thread is eligible. TS_DRAIN means instructions are in flight and no credit is left; the thread is blocked. TS_MEMWAIT means a memory operation is outstanding; the thread is blocked. The transitions are:
- issue of a non-memory instruction from TS_IDLE or TS_GROUP goes to TS_GROUP when the new credit is non-zero, and to TS_DRAIN otherwise;
- issue of a memory instruction from either eligible state goes to TS_MEMWAIT;
- pipeline expiry takes TS_GROUP or TS_DRAIN to TS_IDLE once `DEPTH` cycles have passed since the last issue;
- a completion pulse takes TS_MEMWAIT to TS_IDLE.

A round-robin arbiter chooses among the eligible threads that have an instruction. It starts searching from the thread after the last one that issued. The grant is combinational from the registered state and the current inputs.

Top module: `lais_issue_sel`

## Requirements
- R1: At most one thread is granted per cycle. `issue_valid` is high only when the granted thread has `inst_rdy` set and is eligible, and it is low when no ready thread is eligible.
- R2: Whenever at least one ready thread is eligible, `issue_valid` is high in that cycle.
- R3: Among ready eligible threads, the grant goes to the first one found searching upward, with wraparound, from the thread after the last thread that issued. After reset the search starts at thread 0.
- R4: When a thread with nothing in flight issues a non-memory instruction, its credit is loaded with that instruction's lookahead value. The lookahead is 3 bits and holds 0 to 7, at bits [3i+2:3i] of `inst_la` for thread i.
- R5: When a thread with instructions in flight and credit c > 0 issues a non-memory instruction with lookahead L, its new credit is min(c-1, L).
- R6: A thread with zero credit and an instruction in flight is not granted. If its last issue was in cycle t, it is not granted again before cycle t+DEPTH and is eligible from cycle t+DEPTH.
- R7: Once `DEPTH` cycles pass after a thread's last issue, its group closes even if credit is left. The next issue loads a fresh credit as in R4.
- R8: A thread that issues with `inst_mem` set is not granted until a `mem_done` pulse for it arrives. It is eligible from the cycle after the pulse, with nothing in flight.
- R9: A `mem_done` pulse for a thread that has no outstanding memory operation has no effect.
- R10: After reset every thread has nothing in flight, and `issue_valid` is low while no `inst_rdy` bit is set.
- R11: The grant for a cycle depends on that cycle's `inst_rdy`, `inst_la` and `inst_mem` inputs, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_rdy | input | NTHR | Thread i has an instruction ready to issue |
| inst_la | input | 3*NTHR | Lookahead count of each thread's ready instruction |
| inst_mem | input | NTHR | Ready instruction of thread i is a memory operation |
| mem_done | input | NTHR | Completion pulse for thread i's memory operation |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | $clog2(NTHR) | Index of the granted thread |

## Verification
A behavioural reference model in the bench predicts the grant on every cycle and compares it with the design. The stimulus runs through several distinct phases:
- A single thread with zero lookahead shows the exact `DEPTH`-cycle spacing of dependent issues.
- A single thread with large and then shrinking lookahead values separates a design that reloads credit on every issue from one that takes the minimum.
- A burst followed by a long gap tells group expiry apart from credit exhaustion.
- A memory operation held for 150 cycles, with stray completion pulses sent to other threads, covers the memory wait and the pulses that must be ignored.
- All threads ready at once expose the round-robin order.
- A long random phase mixes every case.

// File: rtl/lais_pkg.sv
package lais_pkg;

    localparam int LA_W = 3;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_GROUP,
        TS_DRAIN,
        TS_MEMWAIT
    } thr_state_e;

endpackage

// File: rtl/lais_thread.sv
module lais_thread
    import lais_pkg::*;
#(
    parameter int DEPTH = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic [LA_W-1:0] la,
    input  logic            mem,
    input  logic            done,
    output logic            eligible,
    output thr_state_e      state_o
);

    localparam int TMW = $clog2(DEPTH + 1);
    localparam logic [TMW-1:0] RELOAD = TMW'(DEPTH - 1);

    thr_state_e      state_q, state_d;
    logic [LA_W-1:0] credit_q, credit_d;
    logic [TMW-1:0]  timer_q, timer_d;
    logic [LA_W-1:0] credit_dec;
    logic [LA_W-1:0] credit_new;

    always_comb begin
        credit_dec = credit_q - LA_W'(1);
        if (state_q == TS_GROUP) begin
            credit_new = (credit_dec < la) ? credit_dec : la;
        end else begin
            credit_new = la;
        end
    end

    always_comb begin
        state_d  = state_q;
        credit_d = credit_q;
        timer_d  = timer_q;
        unique case (state_q)
            TS_IDLE, TS_GROUP: begin
                if (grant) begin
                    if (mem) begin
                        state_d  = TS_MEMWAIT;
                        credit_d = '0;
                        timer_d  = '0;
                    end else begin
                        state_d  = (credit_new != '0) ? TS_GROUP : TS_DRAIN;
                        credit_d = credit_new;
                        timer_d  = RELOAD;
                    end
                end else if (state_q == TS_GROUP) begin
                    if (timer_q == TMW'(1)) begin
                        state_d  = TS_IDLE;
                        credit_d = '0;
                        timer_d  = '0;
                    end else begin
                        timer_d = timer_q - TMW'(1);
                    end
                end
            end
            TS_DRAIN: begin
                if (timer_q == TMW'(1)) begin
                    state_d = TS_IDLE;
                    timer_d = '0;
                end else begin
                    timer_d = timer_q - TMW'(1);
                end
            end
            TS_MEMWAIT: begin
                if (done) begin
                    state_d = TS_IDLE;
                end
            end
            default: state_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TS_IDLE;
            credit_q <= '0;
            timer_q  <= '0;
        end else begin
            state_q  <= state_d;
            credit_q <= credit_d;
            timer_q  <= timer_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TS_IDLE, TS_GROUP:    eligible = 1'b1;
            TS_DRAIN, TS_MEMWAIT: eligible = 1'b0;
            default:              eligible = 1'b0;
        endcase
        state_o = state_q;
    end

endmodule

// File: rtl/lais_rr.sv
module lais_rr #(
    parameter int NTHR = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTHR-1:0]         req,
    output logic                    gnt_valid,
    output logic [$clog2(NTHR)-1:0] gnt_id
);

    localparam int TIDW = $clog2(NTHR);

    logic [TIDW-1:0] last_q;

    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = 1; k <= NTHR; k++) begin
            idx = (int'(last_q) + k) % NTHR;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = TIDW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= TIDW'(NTHR - 1);
        end else if (gnt_valid) begin
            last_q <= gnt_id;
        end
    end

endmodule

// File: rtl/lais_issue_sel.sv
module lais_issue_sel
    import lais_pkg::*;
#(
    parameter int NTHR  = 16,
    parameter int DEPTH = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTHR-1:0]         inst_rdy,
    input  logic [NTHR*LA_W-1:0]    inst_la,
    input  logic [NTHR-1:0]         inst_mem,
    input  logic [NTHR-1:0]         mem_done,
    output logic                    issue_valid,
    output logic [$clog2(NTHR)-1:0] issue_tid
);

    localparam int TIDW = $clog2(NTHR);

    logic [NTHR-1:0] elig_w;
    logic [NTHR-1:0] req_w;
    logic [NTHR-1:0] grant_w;
    thr_state_e      st_w [NTHR];

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        assign grant_w[i] = issue_valid && (issue_tid == TIDW'(i));

        lais_thread #(.DEPTH(DEPTH)) u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant    (grant_w[i]),
            .la       (inst_la[i*LA_W +: LA_W]),
            .mem      (inst_mem[i]),
            .done     (mem_done[i]),
            .eligible (elig_w[i]),
            .state_o  (st_w[i])
        );
    end

    assign req_w = inst_rdy & elig_w;

    lais_rr #(.NTHR(NTHR)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_w),
        .gnt_valid (issue_valid),
        .gnt_id    (issue_tid)
    );

endmodule

// File: rtl/lais_issue_sel_chk.sv
module lais_issue_sel_chk
    import lais_pkg::*;
#(
    parameter int NTHR = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NTHR-1:0]         inst_rdy,
    input logic [NTHR-1:0]         mem_done,
    input logic [NTHR-1:0]         elig,
    input logic                    issue_valid,
    input logic [$clog2(NTHR)-1:0] issue_tid,
    input thr_state_e              thr_st [NTHR]
);

    localparam int TIDW = $clog2(NTHR);

    a_r1_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (inst_rdy[issue_tid] && elig[issue_tid]));

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(inst_rdy & elig)) |-> !issue_valid);

    a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|(inst_rdy & elig)) |-> issue_valid);

    for (genvar i = 0; i < NTHR; i++) begin : g_chk
        a_r6_drain_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_st[i] == TS_DRAIN) |-> !(issue_valid && issue_tid == TIDW'(i)));

        a_r8_memwait_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_st[i] == TS_MEMWAIT && !mem_done[i]) |=> (thr_st[i] == TS_MEMWAIT));

        a_r8_memwait_release: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_st[i] == TS_MEMWAIT && mem_done[i]) |=> (thr_st[i] == TS_IDLE));

        a_r9_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_st[i] == TS_IDLE && mem_done[i] && !(issue_valid && issue_tid == TIDW'(i)))
            |=> (thr_st[i] == TS_IDLE));
    end

endmodule

bind lais_issue_sel lais_issue_sel_chk #(.NTHR(NTHR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inst_rdy    (inst_rdy),
    .mem_done    (mem_done),
    .elig        (elig_w),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .thr_st      (st_w)
);

// File: tb/test_lais_issue_sel.sv
`timescale 1ns/1ps
module test_lais_issue_sel;

    localparam int NTHR  = 8;
    localparam int DEPTH = 6;
    localparam int TIDW  = $clog2(NTHR);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NTHR-1:0]      inst_rdy = '0;
    logic [NTHR*3-1:0]    inst_la = '0;
    logic [NTHR-1:0]      inst_mem = '0;
    logic [NTHR-1:0]      mem_done = '0;
    logic                 issue_valid;
    logic [TIDW-1:0]      issue_tid;

    int checks = 0;
    int errors = 0;

    int credit [NTHR];
    int busy_until [NTHR];
    bit memw [NTHR];
    int last;
    int cyc;

    always #2.5 clk = ~clk;

    lais_issue_sel #(.NTHR(NTHR), .DEPTH(DEPTH)) i_lais_issue_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .inst_rdy    (inst_rdy),
        .inst_la     (inst_la),
        .inst_mem    (inst_mem),
        .mem_done    (mem_done),
        .issue_valid (issue_valid),
        .issue_tid   (issue_tid)
    );

    task automatic model_reset();
        for (int i = 0; i < NTHR; i++) begin
            credit[i] = 0;
            busy_until[i] = 0;
            memw[i] = 0;
        end
        last = NTHR - 1;
        cyc = 0;
    endtask

    function automatic int la_of(int i);
        return int'(inst_la[i*3 +: 3]);
    endfunction

    // Called right after a falling edge with inputs set; compares and advances.
    task automatic step(string tag);
        bit ev;
        int et;
        bit el;
        #1;
        ev = 0;
        et = 0;
        for (int k = 1; k <= NTHR; k++) begin
            int t;
            t = (last + k) % NTHR;
            el = !memw[t] && ((cyc >= busy_until[t]) || credit[t] > 0);
            if (!ev && inst_rdy[t] && el) begin
                ev = 1;
                et = t;
            end
        end
        checks++;
        if (issue_valid !== ev || (ev && int'(issue_tid) != et)) begin
            errors++;
            $display("FAIL %s cycle %0d: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     tag, cyc, issue_valid, issue_tid, ev, et);
        end
        for (int i = 0; i < NTHR; i++) begin
            if (memw[i] && mem_done[i]) begin
                memw[i] = 0;
                busy_until[i] = 0;
                credit[i] = 0;
            end
        end
        if (ev) begin
            if (inst_mem[et]) begin
                memw[et] = 1;
            end else begin
                if (cyc < busy_until[et]) begin
                    credit[et] = (credit[et] - 1 < la_of(et)) ? credit[et] - 1 : la_of(et);
                end else begin
                    credit[et] = la_of(et);
                end
                busy_until[et] = cyc + DEPTH;
            end
            last = et;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic set_la_all(int v);
        for (int i = 0; i < NTHR; i++) inst_la[i*3 +: 3] = 3'(v);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: idle after reset, no grant without ready
        step("R10");
        step("R10");
        // R10 / R3: all ready, thread 0 first
        inst_rdy = '1;
        set_la_all(0);
        step("R10");
        inst_rdy = '0;
        repeat (DEPTH) step("R10");

        // R6 / R11: single thread, zero lookahead, spaced by DEPTH
        inst_rdy = 8'b0000_1000;
        repeat (3 * DEPTH) step("R6");
        inst_rdy = '0;
        repeat (DEPTH) step("R11");

        // R4: lookahead 3 lets four back-to-back issues
        inst_la[5*3 +: 3] = 3'd3;
        inst_rdy = 8'b0010_0000;
        repeat (2 * DEPTH) step("R4");
        // R5: shrinking lookahead after a large one
        inst_rdy = '0;
        repeat (DEPTH) step("R5");
        inst_rdy = 8'b0010_0000;
        inst_la[5*3 +: 3] = 3'd7;
        step("R5");
        inst_la[5*3 +: 3] = 3'd1;
        repeat (2 * DEPTH) step("R5");
        inst_rdy = '0;
        repeat (DEPTH) step("R5");

        // R7: group expires with credit left, fresh load afterwards
        inst_la[2*3 +: 3] = 3'd7;
        inst_rdy = 8'b0000_0100;
        step("R7");
        inst_rdy = '0;
        repeat (DEPTH + 2) step("R7");
        inst_la[2*3 +: 3] = 3'd2;
        inst_rdy = 8'b0000_0100;
        repeat (2 * DEPTH) step("R7");
        inst_rdy = '0;
        repeat (DEPTH) step("R7");

        // R8 / R9: memory op waits for its pulse, stray pulses ignored
        inst_mem[1] = 1'b1;
        inst_rdy = 8'b0000_0010;
        step("R8");
        inst_mem[1] = 1'b0;
        for (int c = 0; c < 150; c++) begin
            mem_done = (c % 7 == 3) ? 8'b1000_0001 : 8'b0;
            step("R9");
        end
        mem_done = 8'b0000_0010;
        step("R8");
        mem_done = '0;
        repeat (2 * DEPTH) step("R8");
        inst_rdy = '0;
        repeat (DEPTH) step("R8");

        // R3: all threads ready, round robin rotation
        set_la_all(0);
        inst_rdy = '1;
        repeat (4 * NTHR) step("R3");
        inst_rdy = 8'b1010_0101;
        set_la_all(1);
        repeat (4 * NTHR) step("R3");

        // R1 / R2: random mix
        for (int c = 0; c < 4000; c++) begin
            inst_rdy = 8'($urandom);
            for (int i = 0; i < NTHR; i++) begin
                inst_la[i*3 +: 3] = 3'($urandom_range(0, 7));
                inst_mem[i] = ($urandom_range(0, 19) == 0);
                mem_done[i] = ($urandom_range(0, 9) == 0);
            end
            step((c % 2 == 0) ? "R1" : "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule